// File: doc/BRIEF.md
# Transmit DMA Channel Run-State Controller

This block sequences one transmit DMA channel that walks a list of descriptors in memory. It holds the channel in one of three visible states: Stopped, Running or Suspended. It keeps the descriptor pointer and issues descriptor fetch requests. When a fetched descriptor still belongs to software, it raises a buffer-unavailable flag. Software drives a level start bit, may load a new list base while that bit is low, and clears the flag by writing one. The fetch engine answers each request with a done strobe and an ownership bit. The data mover signals the end of each packet.

Internally the controller has five phases. The visible state maps them as follows:

| Phase | Reported as | Meaning |
|---|---|---|
| IDLE | Stopped | Channel is off. |
| FETCH | Running | Descriptor fetch in flight. |
| MOVE | Running | Packet in progress. |
| HOLD | Suspended | Waiting after an unowned descriptor. |
| REPOLL | Suspended | Fetching the same descriptor again after a resume strobe. |

The transitions are:

- IDLE→FETCH on start.
- FETCH→MOVE on an owned descriptor.
- FETCH→HOLD on an unowned descriptor.
- MOVE→FETCH on packet end with the start bit high.
- MOVE→IDLE on packet end with the start bit low.
- HOLD→IDLE when the start bit is low.
- HOLD→REPOLL on resume.
- REPOLL→MOVE on an owned descriptor.
- REPOLL→HOLD on an unowned descriptor.

Top module: `txdma_runctl`

## Requirements
- R1: After reset, `chan_state` is 0 (Stopped), `fetch_req` is 0, `nobuf_flag` is 0 and `fetch_addr` is 0. Encoding: 0 = Stopped, 1 = Running, 2 = Suspended.
- R2: In Stopped with `run_en` high at a clock edge, the next cycle shows `chan_state`=1 and `fetch_req`=1, with `fetch_addr` equal to the held pointer.
- R3: A `base_wr` strobe with `run_en` low loads `list_base` into the pointer, visible on `fetch_addr` the next cycle. With `run_en` high the strobe is ignored.
- R4: `fetch_req` stays high until a `fetch_done` strobe. A `fetch_done` arriving while no request is open changes no output.
- R5: An answered fetch with `fetch_owned`=1 gives Running with `fetch_req`=0 (packet in progress). With `fetch_owned`=0 it gives `chan_state`=2 and sets `nobuf_flag`.
- R6: `pkt_done` while a packet is in progress and `run_en` is high advances `fetch_addr` by DESC_BYTES (default 16) and raises `fetch_req` in the next cycle.
- R7: Lowering `run_en` during a fetch or packet keeps the channel Running. The next `pkt_done` then gives Stopped with the pointer advanced by DESC_BYTES.
- R8: In Suspended with `run_en` low, the channel becomes Stopped the next cycle with the pointer unchanged.
- R9: A restart from Stopped fetches from the pointer saved at the stop.
- R10: In Suspended, a `resume` strobe with `run_en` high refetches the same address while still reporting Suspended. An owned answer then gives Running; an unowned one gives Suspended again.
- R11: `nobuf_clr`=1 clears `nobuf_flag`. A set in the same cycle wins over the clear, and a set while the flag is already high leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Software start bit (level) |
| base_wr | input | 1 | Strobe: new list base written |
| list_base | input | AW | Descriptor list base address |
| fetch_done | input | 1 | Descriptor fetch answered |
| fetch_owned | input | 1 | Answered descriptor is owned by the DMA |
| pkt_done | input | 1 | Current packet finished |
| resume | input | 1 | Poll/resume strobe |
| nobuf_clr | input | 1 | Write-one-to-clear for the flag |
| chan_state | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | AW | Address of the descriptor to fetch |
| nobuf_flag | output | 1 | Buffer-unavailable status |

## Verification
The flag-setting path and the software clear can meet in one cycle. An unowned descriptor answer can arrive in the same cycle that software writes the clear. The bench provokes this by presenting `fetch_done` with `fetch_owned` low together with `nobuf_clr`. It judges the result by the flag staying high in the next cycle while the state becomes Suspended. A second overlap is a stop request landing while a packet or fetch is still in flight. The bench expects Running to persist until `pkt_done`.

// File: rtl/txdma_rc_pkg.sv
package txdma_rc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FETCH  = 3'd1,
        PH_MOVE   = 3'd2,
        PH_HOLD   = 3'd3,
        PH_REPOLL = 3'd4
    } ph_t;

    localparam logic [1:0] CS_STOPPED   = 2'd0;
    localparam logic [1:0] CS_RUNNING   = 2'd1;
    localparam logic [1:0] CS_SUSPENDED = 2'd2;
endpackage

// File: rtl/txdma_rc_fsm.sv
module txdma_rc_fsm
    import txdma_rc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       fetch_done,
    input  logic       fetch_owned,
    input  logic       pkt_done,
    input  logic       resume,
    output logic       adv,
    output logic       nobuf_set,
    output logic       fetch_req,
    output logic [1:0] chan_state
);
    ph_t ph_q, ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:   if (run_en) ph_d = PH_FETCH;
            PH_FETCH,
            PH_REPOLL: if (fetch_done) ph_d = fetch_owned ? PH_MOVE : PH_HOLD;
            PH_MOVE:   if (pkt_done) ph_d = run_en ? PH_FETCH : PH_IDLE;
            PH_HOLD:   if (!run_en) ph_d = PH_IDLE;
                       else if (resume) ph_d = PH_REPOLL;
            default:   ph_d = PH_IDLE;
        endcase
    end

    always_comb begin
        fetch_req  = 1'b0;
        chan_state = CS_STOPPED;
        unique case (ph_q)
            PH_IDLE:   chan_state = CS_STOPPED;
            PH_FETCH:  begin chan_state = CS_RUNNING;   fetch_req = 1'b1; end
            PH_MOVE:   chan_state = CS_RUNNING;
            PH_HOLD:   chan_state = CS_SUSPENDED;
            PH_REPOLL: begin chan_state = CS_SUSPENDED; fetch_req = 1'b1; end
            default:   chan_state = CS_STOPPED;
        endcase
        adv       = (ph_q == PH_MOVE) && pkt_done;
        nobuf_set = fetch_req && fetch_done && !fetch_owned;
    end

    // R4
    req_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (chan_state != CS_STOPPED));
    // R8
    susp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_state == CS_SUSPENDED && !fetch_req && !run_en) |=> (chan_state == CS_STOPPED));
    // R6
    next_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_state == CS_RUNNING && !fetch_req && pkt_done && run_en) |=> fetch_req);
    // R7
    stop_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_state == CS_RUNNING && !pkt_done && !(fetch_req && fetch_done && !fetch_owned))
        |=> (chan_state == CS_RUNNING));
endmodule

// File: rtl/txdma_rc_ptr.sv
module txdma_rc_ptr #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          base_wr,
    input  logic [AW-1:0] list_base,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    logic load;
    assign load = base_wr && !run_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (adv)  ptr <= ptr + STEP;
        else if (load) ptr <= list_base;
    end

    // R3
    base_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(ptr));
    // R6
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ptr - $past(ptr) == STEP));
endmodule

// File: rtl/txdma_rc_flag.sv
module txdma_rc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (set_i)  flag <= 1'b1;
        else if (clr_i)  flag <= 1'b0;
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag);
    // R11
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag);
endmodule

// File: rtl/txdma_runctl.sv
module txdma_runctl #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          base_wr,
    input  logic [AW-1:0] list_base,
    input  logic          fetch_done,
    input  logic          fetch_owned,
    input  logic          pkt_done,
    input  logic          resume,
    input  logic          nobuf_clr,
    output logic [1:0]    chan_state,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          nobuf_flag
);
    logic adv, nobuf_set;

    txdma_rc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .fetch_done  (fetch_done),
        .fetch_owned (fetch_owned),
        .pkt_done    (pkt_done),
        .resume      (resume),
        .adv         (adv),
        .nobuf_set   (nobuf_set),
        .fetch_req   (fetch_req),
        .chan_state  (chan_state)
    );

    txdma_rc_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .base_wr   (base_wr),
        .list_base (list_base),
        .adv       (adv),
        .ptr       (fetch_addr)
    );

    txdma_rc_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (nobuf_set),
        .clr_i (nobuf_clr),
        .flag  (nobuf_flag)
    );

    // R5
    unowned_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_done && !fetch_owned) |=> (chan_state == 2'd2 && nobuf_flag));
endmodule

// File: tb/sim_txdma_runctl.sv
module sim_txdma_runctl;
    localparam int AW = 32;
    localparam int NV = 24;
    // {run,bwr,fdone,fown,pdone,res,clr,0}, base[15:0], {state[1:0],req,flag}, addr[15:0]
    localparam logic [43:0] VEC [NV] = '{
        {8'b0100_0000, 16'h1000, 4'b0000, 16'h1000}, // R3 load base
        {8'b1000_0000, 16'h0000, 4'b0110, 16'h1000}, // R2 start
        {8'b1011_0000, 16'h0000, 4'b0100, 16'h1000}, // R5 owned
        {8'b1000_1000, 16'h0000, 4'b0110, 16'h1010}, // R6 advance
        {8'b1010_0000, 16'h0000, 4'b1001, 16'h1010}, // R5 unowned
        {8'b1100_0000, 16'h2000, 4'b1001, 16'h1010}, // R3 ignored
        {8'b1000_0100, 16'h0000, 4'b1011, 16'h1010}, // R10 resume
        {8'b1010_0000, 16'h0000, 4'b1001, 16'h1010}, // R10 R11 still unowned
        {8'b1000_0010, 16'h0000, 4'b1000, 16'h1010}, // R11 clear
        {8'b1000_0100, 16'h0000, 4'b1010, 16'h1010}, // R10 resume
        {8'b1011_0000, 16'h0000, 4'b0100, 16'h1010}, // R10 owned
        {8'b0000_0000, 16'h0000, 4'b0100, 16'h1010}, // R7 deferred
        {8'b0000_1000, 16'h0000, 4'b0000, 16'h1020}, // R7 stop
        {8'b1000_0000, 16'h0000, 4'b0110, 16'h1020}, // R9 restart
        {8'b1010_0010, 16'h0000, 4'b1001, 16'h1020}, // R11 set wins
        {8'b0000_0000, 16'h0000, 4'b0001, 16'h1020}, // R8 susp stop
        {8'b0100_0000, 16'h3000, 4'b0001, 16'h3000}, // R3 new base
        {8'b0000_0010, 16'h0000, 4'b0000, 16'h3000}, // R11 clear
        {8'b1000_0000, 16'h0000, 4'b0110, 16'h3000}, // R9 start at new base
        {8'b1011_0000, 16'h0000, 4'b0100, 16'h3000}, // R5
        {8'b1000_1000, 16'h0000, 4'b0110, 16'h3010}, // R6
        {8'b0011_0000, 16'h0000, 4'b0100, 16'h3010}, // R7 stop during fetch
        {8'b0000_1000, 16'h0000, 4'b0000, 16'h3020}, // R7
        {8'b0010_0000, 16'h0000, 4'b0000, 16'h3020}  // R4 stray done
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0, base_wr = 1'b0, fetch_done = 1'b0, fetch_owned = 1'b0;
    logic pkt_done = 1'b0, resume = 1'b0, nobuf_clr = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic [1:0] chan_state;
    logic fetch_req, nobuf_flag;
    logic [AW-1:0] fetch_addr;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    txdma_runctl #(.AW(AW), .DESC_BYTES(16)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .base_wr(base_wr),
        .list_base(list_base), .fetch_done(fetch_done), .fetch_owned(fetch_owned),
        .pkt_done(pkt_done), .resume(resume), .nobuf_clr(nobuf_clr),
        .chan_state(chan_state), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .nobuf_flag(nobuf_flag)
    );

    task automatic check(input string tag, input logic [1:0] st, input logic rq,
                         input logic fl, input logic [AW-1:0] ad);
        n_chk++;
        if (chan_state !== st || fetch_req !== rq || nobuf_flag !== fl || fetch_addr !== ad) begin
            n_bad++;
            $display("FAIL %s: got st=%0d req=%0b flag=%0b addr=%h, want st=%0d req=%0b flag=%0b addr=%h",
                     tag, chan_state, fetch_req, nobuf_flag, fetch_addr, st, rq, fl, ad);
        end
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset", 2'd0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 2'd0, 1'b0, 1'b0, '0);
        for (int i = 0; i < NV; i++) begin
            {run_en, base_wr, fetch_done, fetch_owned, pkt_done, resume, nobuf_clr} = VEC[i][43:37];
            list_base = {16'h0, VEC[i][35:20]};
            @(posedge clk);
            #1;
            check($sformatf("R2-R11 vector %0d", i), VEC[i][19:18], VEC[i][17],
                  VEC[i][16], {16'h0, VEC[i][15:0]});
            @(negedge clk);
        end
        {run_en, base_wr, fetch_done, fetch_owned, pkt_done, resume, nobuf_clr} = '0;
        // R2: start is level; hold several idle cycles with run low -> stays stopped
        repeat (3) @(negedge clk);
        check("R2 no start", 2'd0, 1'b0, 1'b0, 32'h3020);
        run_en = 1'b1;
        @(negedge clk);
        check("R9 restart", 2'd1, 1'b1, 1'b0, 32'h3020);
        // R4: request held with no answer
        repeat (3) @(negedge clk);
        check("R4 held", 2'd1, 1'b1, 1'b0, 32'h3020);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 2'd0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        run_en = 1'b0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule